// File: doc/BRIEF.md
# Channel-Gain Scan List Sequencer

This block keeps a short programmable list of analog-input conversion entries. Each entry names an input channel, a gain code and whether it closes a scan. The block drives the current entry's channel and gain to the external multiplexer and gain stage. When the converter reports a finished conversion, the block moves on to the next entry.

A host programs the list through two write-only locations. The first is a pointer location that selects a slot. The second is an entry location that stores a word into the slot the pointer selects. Writing zero to the pointer before an acquisition makes the sequence start at the first slot.

A mode input chooses between two ways of working. In scan mode the block walks the list. In single mode it keeps presenting one fixed entry. The block has no length register: the flag inside an entry is what closes a scan. A one-cycle end-of-scan pulse tells the surrounding timing logic that the scan is complete, so it can hold off until the next scan interval. A differential-input input limits the channel field to the eight channels that differential wiring offers.

Top module: `chgain_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, the pointer is 0, every slot holds 0, and `chan`, `gain`, `last` and `scan_end` are all 0.
- R2: A write with `wr_sel`=0 loads `wr_data[3:0]` into the pointer at that clock edge. This load takes priority over a conversion-done pulse in the same cycle.
- R3: A write with `wr_sel`=1 stores `wr_data[7:0]` into the slot the pointer selects and leaves the pointer unchanged. The entry fields are: channel in bits [3:0], last flag in bit 4, gain code in bits [7:6]. Bit 5 is unused.
- R4: `chan`, `gain` and `last` show the fields of the slot at the pointer, with no extra delay after the pointer or the slot changes.
- R5: In scan mode (`scan_en`=1), a `conv_done` pulse on an entry without the last flag moves the pointer up by one.
- R6: In scan mode, a `conv_done` pulse on an entry with the last flag set sends the pointer back to 0.
- R7: In scan mode, when no entry carries the flag, the pointer wraps from 15 to 0.
- R8: In single mode (`scan_en`=0), `conv_done` leaves the pointer unchanged.
- R9: `scan_end` is high for exactly the cycle after a `conv_done`, and only when that conversion closed a scan. A conversion closes a scan if the entry at the pointer had its last flag set in scan mode, or on every conversion in single mode.
- R10: When `diff_mode`=1, bit 3 of `chan` is forced to 0. When `diff_mode`=0, all four channel bits pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 = pointer, 1 = entry |
| wr_data | input | 8 | Host write data |
| scan_en | input | 1 | 1 = walk the list, 0 = fixed entry |
| diff_mode | input | 1 | 1 = differential inputs (8 channels) |
| conv_done | input | 1 | One-cycle conversion-finished pulse |
| chan | output | 4 | Channel number to the multiplexer |
| gain | output | 2 | Gain code to the gain stage |
| last | output | 1 | Last flag of the current entry |
| ptr | output | 4 | Current list pointer |
| scan_end | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench targets these corner cases, and what a wrong design would do in each:
- A pointer write in the same cycle as a conversion pulse. A design that lets the advance win would start the next scan one slot off.
- An entry write in the same cycle as a conversion. Here the write must land in the old slot, and the end-of-scan decision must use the old flag. A design that got this wrong would store the word in the wrong slot or close a scan early.
- A list with no flag at all, which must wrap 15 to 0. A list whose flag sits in the last slot, where the advance and the flag-driven return meet.
- Single mode. A design that kept advancing would change channel under a fixed acquisition and pulse end-of-scan at the wrong rate.
- Differential masking. A design that forgot it would address channels that are not wired.

// File: rtl/chgain_seq.sv
module chgain_seq #(
  parameter int DEPTH = 16,
  parameter int CH_W  = 4,
  parameter int G_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              scan_en,
  input  logic              diff_mode,
  input  logic              conv_done,
  output logic [CH_W-1:0]   chan,
  output logic [G_W-1:0]    gain,
  output logic              last,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic              scan_end
);
  localparam int PW     = $clog2(DEPTH);
  localparam int LAST_B = 4;
  localparam int GAIN_B = 6;
  localparam logic [PW-1:0] TOP = PW'(DEPTH - 1);

  logic [7:0] slot [DEPTH];
  logic [7:0] cur;

  assign cur  = slot[ptr];
  assign last = cur[LAST_B];
  assign gain = cur[GAIN_B +: G_W];
  assign chan = diff_mode ? {1'b0, cur[CH_W-2:0]} : cur[CH_W-1:0];

  wire ptr_wr   = wr_en && !wr_sel;
  wire entry_wr = wr_en && wr_sel;
  wire step     = conv_done && scan_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      scan_end <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      scan_end <= conv_done && (!scan_en || last);
      if (entry_wr) slot[ptr] <= wr_data;
      if (ptr_wr)
        ptr <= wr_data[PW-1:0];
      else if (step)
        ptr <= (last || ptr == TOP) ? '0 : ptr + 1'b1;
    end
  end
endmodule

module chgain_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       scan_en,
  input logic       diff_mode,
  input logic       conv_done,
  input logic [3:0] chan,
  input logic       last,
  input logic [3:0] ptr,
  input logic       scan_end
);
  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> ptr == $past(wr_data[3:0]));
  // R6
  flag_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && conv_done && last && !(wr_en && !wr_sel)) |=> ptr == 4'd0);
  // R5
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && conv_done && !last && !(wr_en && !wr_sel)) |=> ptr == 4'($past(ptr) + 4'd1));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !(wr_en && !wr_sel)) |=> $stable(ptr));
  // R9
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |-> $past(conv_done));
  // R10
  diff_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diff_mode |-> !chan[3]);
endmodule

bind chgain_seq chgain_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .scan_en(scan_en), .diff_mode(diff_mode), .conv_done(conv_done),
  .chan(chan), .last(last), .ptr(ptr), .scan_end(scan_end)
);

// File: tb/chgain_seq_test.sv
module chgain_seq_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, scan_en = 0, diff_mode = 0, conv_done = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] chan, ptr;
  logic [1:0] gain;
  logic last, scan_end;
  int n_run = 0, n_fail = 0;
  logic [7:0] m_mem [16];
  logic [3:0] m_ptr;
  logic m_eos;

  always #5 clk = ~clk;

  chgain_seq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .scan_en(scan_en), .diff_mode(diff_mode),
    .conv_done(conv_done), .chan(chan), .gain(gain), .last(last),
    .ptr(ptr), .scan_end(scan_end));

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_chan(logic [7:0] e, logic d);
    return d ? {1'b0, e[2:0]} : e[3:0];
  endfunction

  task automatic compare(string tag);
    check(tag, "ptr", ptr, m_ptr);
    check(tag, "chan", chan, exp_chan(m_mem[m_ptr], diff_mode));
    check(tag, "gain", gain, m_mem[m_ptr][7:6]);
    check(tag, "last", last, m_mem[m_ptr][4]);
    check(tag, "scan_end", scan_end, m_eos);
  endtask

  task automatic step(string tag, logic we, logic ws, logic [7:0] d, logic cd);
    logic [7:0] cur;
    wr_en = we; wr_sel = ws; wr_data = d; conv_done = cd;
    cur = m_mem[m_ptr];
    m_eos = cd && (!scan_en || cur[4]);
    if (we && ws) m_mem[m_ptr] = d;
    if (we && !ws) m_ptr = d[3:0];
    else if (cd && scan_en) m_ptr = cur[4] ? 4'd0 : m_ptr + 4'd1;
    @(posedge clk); @(negedge clk);
    wr_en = 0; conv_done = 0;
    compare(tag);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    m_ptr = 0; m_eos = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // R3 entry write keeps the pointer, bit 5 is ignored
    step("R2", 1, 0, 8'd5, 0);
    step("R3", 1, 1, 8'hE3, 0);
    check("R3", "gain", gain, 3);
    check("R3", "chan", chan, 3);

    // R5/R6 three-entry list with the flag on entry 2
    step("R2", 1, 0, 8'd0, 0);
    step("R3", 1, 1, 8'h41, 0);
    step("R2", 1, 0, 8'd1, 0);
    step("R3", 1, 1, 8'h82, 0);
    step("R2", 1, 0, 8'd2, 0);
    step("R3", 1, 1, 8'hD4, 0);
    step("R2", 1, 0, 8'd0, 0);
    scan_en = 1;
    step("R5", 0, 0, 0, 1);
    step("R5", 0, 0, 0, 1);
    step("R6", 0, 0, 0, 1);
    check("R9", "scan_end", scan_end, 1);
    check("R6", "ptr", ptr, 0);

    // R7 no flag anywhere: wrap 15 -> 0
    step("R2", 1, 0, 8'd2, 0);
    step("R3", 1, 1, 8'h04, 0);
    step("R2", 1, 0, 8'd14, 0);
    step("R7", 0, 0, 0, 1);
    step("R7", 0, 0, 0, 1);
    check("R7", "ptr", ptr, 0);
    check("R9", "scan_end", scan_end, 0);

    // R2 pointer load wins over conv_done
    step("R2", 1, 0, 8'd9, 1);
    check("R2", "ptr", ptr, 9);

    // R8 single mode holds, pulses every conversion
    scan_en = 0;
    step("R8", 0, 0, 0, 1);
    check("R8", "ptr", ptr, 9);
    check("R9", "scan_end", scan_end, 1);

    // R10 differential masking
    step("R3", 1, 1, 8'h0B, 0);
    diff_mode = 1;
    #1 check("R10", "chan", chan, 3);
    diff_mode = 0;
    #1 check("R10", "chan", chan, 11);

    // R4 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) scan_en = ~scan_en;
      if (r[7:4] == 0) diff_mode = ~diff_mode;
      step("R4", r[8] && r[9], r[10], r[23:16], r[11] || r[12]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule